// File: doc/BRIEF.md
# Refresh Event Counter with Key-Guarded Writes

This block counts compare-match events coming from a separate DRAM refresh timer. Each single-cycle match pulse advances a 10-bit count, which sits in the low bits of a 16-bit register. Once the advanced value would pass a limit chosen by a 2-bit select input, the count returns to zero and a sticky overflow flag rises. Software uses the flag to learn that a set number of refresh intervals has gone by.

Software can preload the count over a simple register bus, with address decoding already done outside the block. A store is accepted only when it is a full 16-bit store that carries a fixed 6-bit key in its upper bits, so a stray byte store or a wrong value cannot corrupt the count. The block has two resets. Power-on reset clears everything. Manual reset leaves the count untouched but clears the flag.

Top module: `refresh_evt_counter`

## Requirements
- R1: `rd_data[9:0]` returns the count and `rd_data[15:10]` always reads 0.
- R2: A `match_pulse` cycle with no accepted write adds one to the count, provided the new value does not exceed the selected limit.
- R3: If count+1 is greater than the limit, the count becomes 0 and `ovf_flag` is set. The limit is 2*(`lim_sel`+1): 2, 4, 6 or 8. A preloaded count that is already above the limit also wraps on the next match.
- R4: `por_n` low clears the count and `ovf_flag` at once, without waiting for a clock edge. Its release passes through a two-stage synchronizer, so counting resumes on the third rising edge after the release.
- R5: A store with `wr_en`=1, `wr_word`=1 and `wr_data[15:10]`=6'b101001 loads `wr_data[9:0]` into the count on the next edge.
- R6: A byte store (`wr_en`=1, `wr_word`=0) has no effect, whatever its data.
- R7: A word store whose bits 15:10 are not 6'b101001 is discarded. It changes neither the count nor `ovf_flag`.
- R8: If an accepted store and a match pulse arrive in the same cycle, the store wins. The match is dropped and no overflow results.
- R9: While `man_rst_n` is low, the count holds its value, `ovf_flag` is cleared, and both stores and matches are ignored.
- R10: `ovf_flag` is sticky and a wrap never clears it. `ovf_clr` clears it, but a wrap in the same cycle as `ovf_clr` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| man_rst_n | input | 1 | Manual reset, synchronous, active low |
| match_pulse | input | 1 | Single-cycle compare-match event from the refresh timer |
| lim_sel | input | 2 | Limit select; limit = 2*(lim_sel+1) |
| wr_en | input | 1 | Register store strobe |
| wr_word | input | 1 | Store size: 1 = 16-bit, 0 = byte |
| wr_data | input | 16 | Store data; bits 15:10 carry the key |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_data | output | 16 | Register read value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a keyed load and a match pulse. The bench provokes it with the count sitting exactly at the limit, so a dropped match is visible in two ways: the loaded value appears instead of zero, and the flag stays low. The second pair is a wrap and an `ovf_clr`. The bench drives both on one edge and expects the flag to stay set. The bench's arithmetic model, which is updated every cycle, judges both cases.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int KEY_W = 6;
  localparam logic [KEY_W-1:0] WR_KEY = 6'b101001;
endpackage

// File: rtl/rfc_rst_sync.sv
module rfc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/rfc_limit_sel.sv
module rfc_limit_sel #(
  parameter int CNT_W    = 10,
  parameter int SEL_W    = 2,
  parameter int LIM_STEP = 2
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W:0]   limit
);
  localparam int LIM_NUM = 1 << SEL_W;

  logic [CNT_W:0] tbl [LIM_NUM];

  for (genvar i = 0; i < LIM_NUM; i++) begin : g_lim
    localparam int LV = (i + 1) * LIM_STEP;
    assign tbl[i] = LV[CNT_W:0];
  end

  assign limit = tbl[sel];
endmodule

// File: rtl/rfc_key_guard.sv
module rfc_key_guard
  import rfc_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int CNT_W = 10
) (
  input  logic             wr_en,
  input  logic             wr_word,
  input  logic [REG_W-1:0] wr_data,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);
  logic [KEY_W-1:0] key_field;

  assign key_field = wr_data[REG_W-1 -: KEY_W];
  assign load      = wr_en && wr_word && (key_field == WR_KEY);
  assign load_val  = wr_data[CNT_W-1:0];
endmodule

// File: rtl/rfc_count_core.sv
module rfc_count_core #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             match,
  input  logic [CNT_W:0]   limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_evt
);
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   inc;
  logic             cnt_en;

  always_comb begin
    cnt_d    = cnt_q;
    wrap_evt = 1'b0;
    inc      = {1'b0, cnt_q} + 1'b1;
    if (!hold) begin
      if (load) begin
        cnt_d = load_val;
      end else if (match) begin
        if (inc > limit) begin
          cnt_d    = '0;
          wrap_evt = 1'b1;
        end else begin
          cnt_d = inc[CNT_W-1:0];
        end
      end
    end
  end

  assign cnt_en = !hold && (load || match);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfc_ovf_flag.sv
module rfc_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic set,
  input  logic clr,
  output logic ovf_q
);
  logic ovf_d;
  logic ovf_en;

  always_comb begin
    if (hold)     ovf_d = 1'b0;
    else if (set) ovf_d = 1'b1;
    else          ovf_d = 1'b0;
  end

  assign ovf_en = hold || set || clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= 1'b0;
    else if (ovf_en) ovf_q <= ovf_d;
  end
endmodule

// File: rtl/refresh_evt_counter.sv
module refresh_evt_counter #(
  parameter int CNT_W     = 10,
  parameter int REG_W     = 16,
  parameter int LIM_SEL_W = 2,
  parameter int LIM_STEP  = 2,
  parameter int SYNC_STG  = 2
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 man_rst_n,
  input  logic                 match_pulse,
  input  logic [LIM_SEL_W-1:0] lim_sel,
  input  logic                 wr_en,
  input  logic                 wr_word,
  input  logic [REG_W-1:0]     wr_data,
  input  logic                 ovf_clr,
  output logic [REG_W-1:0]     rd_data,
  output logic                 ovf_flag
);
  localparam int PAD_W = REG_W - CNT_W;

  logic             rst_n_s;
  logic             hold;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W:0]   limit;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap_evt;

  assign hold = !man_rst_n;

  rfc_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .arst_n(por_n), .rst_n(rst_n_s)
  );

  rfc_limit_sel #(.CNT_W(CNT_W), .SEL_W(LIM_SEL_W), .LIM_STEP(LIM_STEP)) u_lim (
    .sel(lim_sel), .limit(limit)
  );

  rfc_key_guard #(.REG_W(REG_W), .CNT_W(CNT_W)) u_key (
    .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
    .load(load), .load_val(load_val)
  );

  rfc_count_core #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .hold(hold), .load(load),
    .load_val(load_val), .match(match_pulse), .limit(limit),
    .cnt_q(cnt_q), .wrap_evt(wrap_evt)
  );

  rfc_ovf_flag u_ovf (
    .clk(clk), .rst_n(rst_n_s), .hold(hold), .set(wrap_evt),
    .clr(ovf_clr), .ovf_q(ovf_flag)
  );

  assign rd_data = {{PAD_W{1'b0}}, cnt_q};
endmodule

// File: rtl/rfc_chk.sv
module rfc_chk #(
  parameter int CNT_W     = 10,
  parameter int REG_W     = 16,
  parameter int LIM_SEL_W = 2,
  parameter int LIM_STEP  = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 man_rst_n,
  input logic                 match_pulse,
  input logic [LIM_SEL_W-1:0] lim_sel,
  input logic                 wr_en,
  input logic                 wr_word,
  input logic [REG_W-1:0]     wr_data,
  input logic                 ovf_clr,
  input logic [REG_W-1:0]     rd_data,
  input logic                 ovf_flag
);
  logic [CNT_W:0] lim_c;
  logic [CNT_W:0] nxt_c;
  logic           key_wr;
  logic           will_wrap;

  always_comb begin
    lim_c     = CNT_W'(0) + (CNT_W+1)'((int'(lim_sel) + 1) * LIM_STEP);
    nxt_c     = {1'b0, rd_data[CNT_W-1:0]} + 1'b1;
    key_wr    = wr_en && wr_word && (wr_data[REG_W-1 -: 6] == 6'b101001);
    will_wrap = man_rst_n && match_pulse && !key_wr && (nxt_c > lim_c);
  end

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:CNT_W] == '0);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst_n && match_pulse && !key_wr && (nxt_c <= lim_c)
    |=> rd_data[CNT_W-1:0] == $past(rd_data[CNT_W-1:0]) + 1'b1);

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    will_wrap |=> (rd_data[CNT_W-1:0] == '0) && ovf_flag);

  // R5
  key_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst_n && key_wr |=> rd_data[CNT_W-1:0] == $past(wr_data[CNT_W-1:0]));

  // R6
  byte_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst_n && wr_en && !wr_word && !match_pulse |=> $stable(rd_data));

  // R9
  manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !man_rst_n |=> $stable(rd_data) && !ovf_flag);

  // R10
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst_n && ovf_clr && !will_wrap |=> !ovf_flag);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst_n && ovf_flag && !ovf_clr |=> ovf_flag);
endmodule

bind refresh_evt_counter rfc_chk #(
  .CNT_W(CNT_W), .REG_W(REG_W), .LIM_SEL_W(LIM_SEL_W), .LIM_STEP(LIM_STEP)
) u_rfc_chk (
  .clk(clk), .rst_n(rst_n_s), .man_rst_n(man_rst_n), .match_pulse(match_pulse),
  .lim_sel(lim_sel), .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
  .ovf_clr(ovf_clr), .rd_data(rd_data), .ovf_flag(ovf_flag)
);

// File: tb/refresh_evt_counter_bench.sv
module refresh_evt_counter_bench;
  logic        clk = 1'b0;
  logic        por_n;
  logic        man_rst_n;
  logic        match_pulse;
  logic [1:0]  lim_sel;
  logic        wr_en;
  logic        wr_word;
  logic [15:0] wr_data;
  logic        ovf_clr;
  logic [15:0] rd_data;
  logic        ovf_flag;

  int checks = 0;
  int errors = 0;

  int m_cnt;
  bit m_ovf;

  always #5 clk = ~clk;

  refresh_evt_counter u_refresh_evt_counter (
    .clk(clk), .por_n(por_n), .man_rst_n(man_rst_n), .match_pulse(match_pulse),
    .lim_sel(lim_sel), .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
    .ovf_clr(ovf_clr), .rd_data(rd_data), .ovf_flag(ovf_flag)
  );

  function automatic int lim_of(input logic [1:0] s);
    return 2 * (int'(s) + 1);
  endfunction

  task automatic check_out(input string tag);
    checks++;
    if (rd_data !== 16'(m_cnt) || ovf_flag !== m_ovf) begin
      errors++;
      $display("FAIL %s: rd_data=%h ovf=%b expected rd_data=%h ovf=%b",
               tag, rd_data, ovf_flag, 16'(m_cnt), m_ovf);
    end
  endtask

  // One clock: drive after the falling edge, update model at rising edge, check after it.
  task automatic step(input bit m, input bit we, input bit ww, input logic [15:0] d,
                      input bit clr, input bit mr_n, input string tag);
    bit wrap;
    int nx;
    @(negedge clk);
    match_pulse = m; wr_en = we; wr_word = ww; wr_data = d;
    ovf_clr = clr; man_rst_n = mr_n;
    @(posedge clk);
    wrap = 1'b0;
    if (!mr_n) begin
      m_ovf = 1'b0;
    end else begin
      if (we && ww && d[15:10] == 6'b101001) begin
        m_cnt = int'(d[9:0]);
      end else if (m) begin
        nx = m_cnt + 1;
        if (nx > lim_of(lim_sel)) begin
          m_cnt = 0;
          wrap  = 1'b1;
        end else begin
          m_cnt = nx;
        end
      end
      if (wrap)     m_ovf = 1'b1;
      else if (clr) m_ovf = 1'b0;
    end
    #1;
    check_out(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 16'h0, 0, 1, tag);
  endtask

  task automatic power_on(input string tag);
    @(negedge clk);
    por_n = 1'b0;
    #1;
    m_cnt = 0;
    m_ovf = 1'b0;
    check_out(tag);
    @(negedge clk);
    @(negedge clk);
    por_n = 1'b1;
    idle(3, tag);
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
  end

  initial begin
    por_n = 1'b0; man_rst_n = 1'b1; match_pulse = 1'b0; lim_sel = 2'd0;
    wr_en = 1'b0; wr_word = 1'b0; wr_data = 16'h0; ovf_clr = 1'b0;
    m_cnt = 0; m_ovf = 1'b0;
    #23;
    check_out("R4 reset state");
    power_on("R4 power-on");

    // R2 R3 R1: count through several wraps for every limit select
    for (int s = 0; s < 4; s++) begin
      lim_sel = 2'(s);
      power_on("R4 per-limit reset");
      for (int p = 0; p < 3 * (lim_of(2'(s)) + 1) + 1; p++) begin
        step(1, 0, 0, 16'h0, 0, 1, "R2/R3 match sweep");
        if (p % 3 == 1) step(0, 0, 0, 16'h0, 0, 1, "R2 gap");
      end
      step(0, 0, 0, 16'h0, 0, 1, "R10 sticky after wraps");
      step(0, 0, 0, 16'h0, 1, 1, "R10 clear");
    end

    // R5: keyed loads, then match from loaded values including above-limit
    lim_sel = 2'd3;
    step(0, 1, 1, {6'b101001, 10'd5}, 0, 1, "R5 load 5");
    step(1, 0, 0, 16'h0, 0, 1, "R2 after load");
    step(0, 1, 1, {6'b101001, 10'd1023}, 0, 1, "R5 load 1023");
    step(1, 0, 0, 16'h0, 0, 1, "R3 wrap from max");
    step(0, 1, 1, {6'b101001, 10'd100}, 0, 1, "R5 load above limit");
    step(1, 0, 0, 16'h0, 0, 1, "R3 wrap above limit");

    // R7: every key value with a word store; only the right key loads
    for (int k = 0; k < 64; k++) begin
      step(0, 1, 1, {6'(k), 10'(3 + k)}, 0, 1, "R7 key sweep");
    end
    // R7: wrong key leaves flag unchanged while set
    step(0, 1, 1, {6'b101001, 10'd8}, 0, 1, "R5 load limit");
    step(1, 0, 0, 16'h0, 0, 1, "R3 wrap sets flag");
    step(0, 1, 1, {6'b101000, 10'd7}, 0, 1, "R7 wrong key flag kept");
    step(0, 1, 1, {6'b001001, 10'd2}, 0, 1, "R7 wrong key flag kept 2");

    // R6: byte stores with the right key and other data are ignored
    for (int b = 0; b < 8; b++) begin
      step(0, 1, 0, {6'b101001, 10'(b * 97)}, 0, 1, "R6 byte ignored");
    end

    // R8: keyed store and match together, count at limit
    step(0, 0, 0, 16'h0, 1, 1, "R10 clear before R8");
    step(0, 1, 1, {6'b101001, 10'd8}, 0, 1, "R5 load limit");
    step(1, 1, 1, {6'b101001, 10'd4}, 0, 1, "R8 store beats match");
    step(1, 1, 0, {6'b101001, 10'd9}, 0, 1, "R6 byte store with match");

    // R10: wrap and clear in the same cycle
    step(0, 1, 1, {6'b101001, 10'd8}, 0, 1, "R5 load limit");
    step(1, 0, 0, 16'h0, 1, 1, "R10 wrap beats clear");
    step(0, 0, 0, 16'h0, 0, 1, "R10 still set");

    // R9: manual reset holds count, clears flag, ignores stores and matches
    step(0, 1, 1, {6'b101001, 10'd3}, 0, 1, "R5 load 3");
    step(1, 0, 0, 16'h0, 0, 1, "R2 to 4");
    step(0, 0, 0, 16'h0, 0, 0, "R9 manual reset");
    step(1, 0, 0, 16'h0, 0, 0, "R9 match ignored");
    step(0, 1, 1, {6'b101001, 10'd77}, 0, 0, "R9 store ignored");
    step(1, 0, 0, 16'h0, 0, 1, "R9 released counts");

    // R4: power-on in mid-run clears asynchronously
    step(0, 1, 1, {6'b101001, 10'd300}, 0, 1, "R5 load 300");
    step(1, 0, 0, 16'h0, 0, 1, "R3 wrap sets flag");
    power_on("R4 mid-run power-on");
    step(1, 0, 0, 16'h0, 0, 1, "R2 after power-on");

    report();
  end
endmodule